// File: doc/BRIEF.md
# Horizontal Minimum With Lane Index

The unit scans a 128-bit word as eight unsigned 16-bit lanes and reports the smallest lane value together with the number of the lane that held it. When several lanes share the smallest value, the lane with the lowest number is reported. Lane 0 occupies the least significant bits of the input.

A producer presents a word with `in_valid_i`. The unit accepts a word on every cycle, so `in_ready_o` is held high. One clock after a word is accepted, `out_valid_o` pulses and `res_o` carries the packed result. Value and index sit in the low 19 bits, and every other bit is zero. The result register keeps its contents until the next accepted word or a reset arrives. The search is a balanced tree of two-input compare-select nodes. Each node passes on its right child only when that child is strictly smaller.

Top module: `hmin_pos_unit`

## Requirements
- R1: Input lane k (k = 0..7) is taken from `vec_i[16k+15:16k]`, and each lane is compared as an unsigned 16-bit number.
- R2: `res_o[15:0]` is no greater than any lane of the accepted word.
- R3: When several lanes hold the minimum, the index reported is the smallest such lane number.
- R4: `res_o[18:16]` holds the 3-bit index of the reported lane, and that lane of the accepted word equals `res_o[15:0]`.
- R5: `res_o[31:19]` is zero.
- R6: `res_o[127:32]` is zero.
- R7: `out_valid_o` is high in exactly the cycle after a cycle with `in_valid_i` high, and low otherwise.
- R8: While `rst_ni` is low, `out_valid_o` and all of `res_o` are zero. The reset is asynchronous and active-low.
- R9: While no word is accepted, `res_o` keeps its previous value.
- R10: `in_ready_o` is high whenever the unit is out of reset, so back-to-back words are each accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Unit can accept a word |
| vec_i | input | 128 | Eight unsigned 16-bit lanes, lane 0 in the low bits |
| out_valid_o | output | 1 | Result registered in the previous cycle is available |
| res_o | output | 128 | Packed result: {96'b0, 13'b0, index, minimum} |

## Verification
A compare node that picks the wrong child shows up in the next cycle as a value above some lane, or as an index with a smaller equal lane below it. The bench catches this with all-equal words, with the minimum placed in lane 7, and with words that separate unsigned from signed ordering. A corrupted result register shows up as a wrong or changing value during idle cycles, or as a stray `out_valid_o` pulse. All of these are visible one clock after the input, or during the idle cycles that follow. Leaf lanes mapped in the wrong order show up as a wrong index on the first asymmetric word.

// File: rtl/hmin_pkg.sv
package hmin_pkg;
  localparam int unsigned LANE_W_DEF = 16;
  localparam int unsigned LANES_DEF  = 8;
endpackage

// File: rtl/hmin_cmp_node.sv
module hmin_cmp_node #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [LANE_W-1:0] lo_val_i,
  input  logic [IDX_W-1:0]  lo_idx_i,
  input  logic [LANE_W-1:0] hi_val_i,
  input  logic [IDX_W-1:0]  hi_idx_i,
  output logic [LANE_W-1:0] win_val_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic take_hi;

  // lo side carries the lower lane numbers: it keeps ties
  assign take_hi   = hi_val_i < lo_val_i;
  assign win_val_o = take_hi ? hi_val_i : lo_val_i;
  assign win_idx_o = take_hi ? hi_idx_i : lo_idx_i;

  always_comb begin
    if (lo_val_i == hi_val_i) begin
      p_tie_keeps_lo_r3: assert (win_idx_o == lo_idx_i);
    end
  end
endmodule

// File: rtl/hmin_tree.sv
module hmin_tree #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 8,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input  logic [VEC_W-1:0]  vec_i,
  output logic [LANE_W-1:0] min_val_o,
  output logic [IDX_W-1:0]  min_idx_o
);
  localparam int unsigned NODES = 2 * LANES - 1;

  // heap order: node k has children 2k+1 and 2k+2, leaves at LANES-1..NODES-1
  logic [LANE_W-1:0] node_val [NODES];
  logic [IDX_W-1:0]  node_idx [NODES];

  for (genvar l = 0; l < LANES; l++) begin : g_leaf
    assign node_val[LANES-1+l] = vec_i[l*LANE_W +: LANE_W];
    assign node_idx[LANES-1+l] = IDX_W'(l);
  end

  for (genvar k = 0; k < LANES - 1; k++) begin : g_node
    hmin_cmp_node #(
      .LANE_W(LANE_W),
      .IDX_W (IDX_W)
    ) i_node (
      .lo_val_i (node_val[2*k+1]),
      .lo_idx_i (node_idx[2*k+1]),
      .hi_val_i (node_val[2*k+2]),
      .hi_idx_i (node_idx[2*k+2]),
      .win_val_o(node_val[k]),
      .win_idx_o(node_idx[k])
    );
  end

  assign min_val_o = node_val[0];
  assign min_idx_o = node_idx[0];
endmodule

// File: rtl/hmin_pack.sv
module hmin_pack #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned VEC_W  = 128
) (
  input  logic [LANE_W-1:0] min_val_i,
  input  logic [IDX_W-1:0]  min_idx_i,
  output logic [VEC_W-1:0]  res_o
);
  localparam int unsigned USED_W = LANE_W + IDX_W;

  assign res_o = {{(VEC_W-USED_W){1'b0}}, min_idx_i, min_val_i};
endmodule

// File: rtl/hmin_pos_unit.sv
module hmin_pos_unit
  import hmin_pkg::*;
#(
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF,
  localparam int unsigned IDX_W = $clog2(LANES),
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [VEC_W-1:0] vec_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] res_o
);
  logic [LANE_W-1:0] tree_val;
  logic [IDX_W-1:0]  tree_idx;
  logic [LANE_W-1:0] res_val_q;
  logic [IDX_W-1:0]  res_idx_q;
  logic              valid_q;
  logic              accept;

  assign in_ready_o = 1'b1;
  assign accept     = in_valid_i & in_ready_o;

  hmin_tree #(
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) i_tree (
    .vec_i    (vec_i),
    .min_val_o(tree_val),
    .min_idx_o(tree_idx)
  );

  // only value and index are stored; zero padding is added after the flops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_val_q <= '0;
      res_idx_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= accept;
      if (accept) begin
        res_val_q <= tree_val;
        res_idx_q <= tree_idx;
      end
    end
  end

  hmin_pack #(
    .LANE_W(LANE_W),
    .IDX_W (IDX_W),
    .VEC_W (VEC_W)
  ) i_pack (
    .min_val_i(res_val_q),
    .min_idx_i(res_idx_q),
    .res_o    (res_o)
  );

  assign out_valid_o = valid_q;

  p_valid_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  p_no_valid_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !out_valid_o);
  p_hold_when_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(res_o));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_min_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> res_o[LANE_W-1:0] <= $past(vec_i[g*LANE_W +: LANE_W]));
    p_idx_names_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (res_o[LANE_W +: IDX_W] != IDX_W'(g))
                 || (res_o[LANE_W-1:0] == $past(vec_i[g*LANE_W +: LANE_W])));
    p_lower_lane_larger_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> (res_o[LANE_W +: IDX_W] <= IDX_W'(g))
                 || (res_o[LANE_W-1:0] != $past(vec_i[g*LANE_W +: LANE_W])));
  end
endmodule

// File: tb/test_hmin_pos_unit.sv
module test_hmin_pos_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic         in_ready_o;
  logic [127:0] vec_i = '0;
  logic         out_valid_o;
  logic [127:0] res_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  hmin_pos_unit i_hmin_pos_unit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .vec_i      (vec_i),
    .out_valid_o(out_valid_o),
    .res_o      (res_o)
  );

  // [159:128] expected low word {13'b0, idx, min}, [127:0] input {lane7..lane0}
  localparam int NV = 7;
  localparam logic [159:0] VEC_TAB [NV] = '{
    {32'h0000_0001, 128'h0008_0007_0006_0005_0004_0003_0002_0001},
    {32'h0007_0001, 128'h0001_0002_0003_0004_0005_0006_0007_0008},
    {32'h0000_1234, 128'h1234_1234_1234_1234_1234_1234_1234_1234},
    {32'h0000_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {32'h0002_0003, 128'h0005_0003_0009_0003_FFFF_0003_8000_7FFF},
    {32'h0005_7FFF, 128'h8000_8000_7FFF_8000_8000_8000_8000_8000},
    {32'h0003_0000, 128'h0100_0000_0100_0100_0000_0100_0100_0100}
  };

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_scan(input logic [127:0] v);
    logic [15:0] best = v[15:0];
    logic [2:0]  bi   = 3'd0;
    for (int k = 1; k < 8; k++) begin
      if (v[k*16 +: 16] < best) begin
        best = v[k*16 +: 16];
        bi   = 3'(k);
      end
    end
    return {13'b0, bi, best};
  endfunction

  // drive at a falling edge, result is sampled at the next falling edge
  task automatic run_one(input logic [127:0] v, input logic [31:0] exp_lo, input string tag);
    @(negedge clk_i);
    vec_i      = v;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(out_valid_o == 1'b1, {tag, " R7"}, 128'(out_valid_o), 128'd1);
    chk(res_o[18:0] == exp_lo[18:0], {tag, " R2/R3/R4"}, res_o, 128'(exp_lo));
    chk(res_o[31:19] == '0, {tag, " R5"}, res_o, 128'(exp_lo));
    chk(res_o[127:32] == '0, {tag, " R6"}, res_o, 128'(exp_lo));
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] held;
    logic [31:0]  seed;
    logic [127:0] rv;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk(out_valid_o == 1'b0, "R8 valid in reset", 128'(out_valid_o), 128'd0);
    chk(res_o == '0, "R8 result in reset", res_o, 128'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R10 ready", 128'(in_ready_o), 128'd1);
    chk(out_valid_o == 1'b0, "R7 idle after reset", 128'(out_valid_o), 128'd0);

    // R1 lane order, table walk
    for (int t = 0; t < NV; t++) begin
      run_one(VEC_TAB[t][127:0], VEC_TAB[t][159:128], $sformatf("R1 tab%0d", t));
    end

    // R9 hold and R7 idle: change input without valid
    held = res_o;
    vec_i = 128'h0;
    repeat (3) begin
      @(negedge clk_i);
      chk(res_o == held, "R9 hold", res_o, held);
      chk(out_valid_o == 1'b0, "R7 no pulse", 128'(out_valid_o), 128'd0);
    end

    // R10 back-to-back words
    @(negedge clk_i);
    vec_i = 128'h0009_0009_0009_0009_0009_0009_0009_0002;
    in_valid_i = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R10 ready b2b", 128'(in_ready_o), 128'd1);
    chk(res_o[31:0] == 32'h0000_0002, "R10 first b2b", res_o, 128'h2);
    vec_i = 128'h0001_0009_0009_0009_0009_0009_0009_0009;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk(out_valid_o == 1'b1, "R7 second b2b", 128'(out_valid_o), 128'd1);
    chk(res_o[31:0] == 32'h0007_0001, "R10 second b2b", res_o, 128'h7_0001);

    // reference scan over pseudo-random words, small range to force ties
    seed = 32'h1ACE_B00C;
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < 8; k++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        rv[k*16 +: 16] = (n < 30) ? {12'h0, seed[3:0]} : seed[31:16];
      end
      run_one(rv, ref_scan(rv), $sformatf("R3 scan%0d", n));
    end

    // R8 asynchronous reset mid-run
    @(negedge clk_i);
    vec_i = 128'h0003_0003_0003_0003_0003_0003_0003_0003;
    in_valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    in_valid_i = 1'b0;
    rst_ni = 1'b0;
    #0.5;
    chk(out_valid_o == 1'b0, "R8 async valid", 128'(out_valid_o), 128'd0);
    chk(res_o == '0, "R8 async result", res_o, 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_one(VEC_TAB[1][127:0], VEC_TAB[1][159:128], "R8 after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule